// File: doc/BRIEF.md
# Vector Element Slide Unit

This block moves the elements of one vector register group up or down by a number of positions and writes the result element by element into a destination group. It supports four flavours in one datapath. Two slide by a scalar amount. Two slide by exactly one position and put a scalar value into the end that is left empty. The caller supplies the operation, the amount, the scalar, the element width, the active and maximum vector lengths, a starting element and a per-element mask. It then raises `start` and waits for `done`.

Source elements come from a read port with one cycle of latency. Results leave through a write port with one element per write. Elements whose mask bit is clear are never written, so the destination keeps its old contents there. When an element width is not allowed for the selected form, the operation ends at once with an exception and writes nothing. On normal completion the block tells the caller to clear its starting-element register.

Top module: `slide_unit`

## Requirements
- R1: With the offset slide upward (`op_down`=0, `op_by_one`=0) and offset k ≤ `vlmax`, element i with i ≥ k receives source element i−k. Elements with i < k are not written.
- R2: With the offset slide downward (`op_down`=1, `op_by_one`=0), element i receives source element i+k when i+k < `vlmax`, and zero otherwise. The sum is formed without overflow for every 32-bit offset, including 0xFFFFFFFF.
- R3: An upward offset slide with k > `vlmax` performs no writes and pulses `done` with `exc`=0 and `vstart_clr`=0. When k = `vlmax`, the operation completes normally with `vstart_clr`=1.
- R4: With the slide-by-one upward form (`op_down`=0, `op_by_one`=1), element 0 receives the scalar and element i ≥ 1 receives source element i−1.
- R5: With the slide-by-one downward form (`op_down`=1, `op_by_one`=1), element i receives source element i+1 when i+1 < `vlmax`, and the scalar otherwise.
- R6: An element i is written only when bit i of `mask` is set. Bit i is bit (i mod 8) of mask byte (i div 8), and byte b occupies `mask[8b+7:8b]`.
- R7: The allowed widths of `elem_bytes` are 4 and 8 when `op_fp`=1, and 1, 2, 4 and 8 when `op_fp`=0. Any other value ends the operation with `done`, `exc`=1, `vstart_clr`=0 and no writes. The R3 no-op case takes precedence over this check.
- R8: Written data is limited to the low 8·`elem_bytes` bits of the source element or the scalar. All higher bits are zero.
- R9: Elements are visited in ascending order from `vstart` up to `vl`−1. If `vstart` ≥ `vl`, nothing is written. A completed operation pulses `vstart_clr` together with `done`.
- R10: `done` is a single-cycle pulse that returns the block to idle. A `start` that arrives while `busy` is high is ignored, and so are changes on the operand inputs during that time.
- R11: After a source read is issued, the matching destination write happens in the following cycle, using `src_data` from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only when idle |
| op_down | input | 1 | 1 = slide toward lower indices |
| op_by_one | input | 1 | 1 = slide-by-one form with scalar insert |
| op_fp | input | 1 | 1 = floating-point form (narrows the legal widths) |
| offset | input | OFF_W | Slide amount for the offset forms, unsigned |
| scalar | input | 64 | Value inserted by the slide-by-one forms |
| elem_bytes | input | 4 | Element width in bytes |
| vl | input | IDX_W | Active vector length |
| vlmax | input | IDX_W | Maximum vector length |
| vstart | input | IDX_W | First element to process |
| mask | input | MAXVL | Mask bytes, packed little-end first |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| exc | output | 1 | Illegal width, valid with done |
| vstart_clr | output | 1 | Caller clears its start register, valid with done |
| src_rd | output | 1 | Source element read request |
| src_idx | output | IDX_W | Source element index |
| src_data | input | 64 | Source element, one cycle after src_rd |
| dst_we | output | 1 | Destination element write |
| dst_idx | output | IDX_W | Destination element index |
| dst_data | output | 64 | Destination element value |

## Verification
A wrong element counter or index sum shows up at the write port on the very element where it goes wrong. The write carries the wrong index or a value from the wrong source slot. The scoreboard catches it at that write, not at the end of the operation. A mistaken mask or range decision appears either as a write that the scoreboard did not expect or as a missing write. A missing write leaves items in the queue when `done` arrives. Wrong launch-time decisions, such as width legality or the oversized upward offset, are visible one cycle after `start`. At that point `done` carries the wrong `exc` or `vstart_clr` flag, or writes begin where none should.

// File: rtl/slide_pkg.sv
package slide_pkg;
  localparam int unsigned ELEM_W = 64;

  typedef enum logic [1:0] {
    ACT_SKIP   = 2'd0,
    ACT_READ   = 2'd1,
    ACT_ZERO   = 2'd2,
    ACT_SCALAR = 2'd3
  } slide_act_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_EVAL   = 2'd1,
    S_RDWAIT = 2'd2,
    S_DONE   = 2'd3
  } slide_state_e;

  function automatic logic [ELEM_W-1:0] width_mask(input logic [3:0] wb);
    case (wb)
      4'd1:    return 64'h0000_0000_0000_00FF;
      4'd2:    return 64'h0000_0000_0000_FFFF;
      4'd4:    return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  function automatic logic width_legal(input logic fp, input logic [3:0] wb);
    if (fp) return (wb == 4'd4) || (wb == 4'd8);
    return (wb == 4'd1) || (wb == 4'd2) || (wb == 4'd4) || (wb == 4'd8);
  endfunction
endpackage

// File: rtl/slide_launch_chk.sv
module slide_launch_chk
  import slide_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int OFF_W = 32
) (
  input  logic             down,
  input  logic             by_one,
  input  logic             fp,
  input  logic [3:0]       wb,
  input  logic [OFF_W-1:0] offset,
  input  logic [IDX_W-1:0] vlmax,
  output logic             noop,
  output logic             bad_width
);
  localparam int CW = OFF_W + IDX_W;

  always_comb begin
    noop      = !down && !by_one && (CW'(offset) > CW'(vlmax));
    bad_width = !width_legal(fp, wb);
  end
endmodule

// File: rtl/slide_src_calc.sv
module slide_src_calc
  import slide_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int OFF_W = 32
) (
  input  logic             down,
  input  logic             by_one,
  input  logic [IDX_W-1:0] idx,
  input  logic [OFF_W-1:0] offset,
  input  logic [IDX_W-1:0] vlmax,
  output slide_act_e       act,
  output logic [IDX_W-1:0] src_idx
);
  localparam int WIDE = ((OFF_W > IDX_W) ? OFF_W : IDX_W) + 2;

  function automatic logic signed [WIDE-1:0] src_pos(input logic dn,
                                                     input logic [IDX_W-1:0] i,
                                                     input logic [OFF_W-1:0] amt);
    logic signed [WIDE-1:0] iw, aw;
    iw = $signed({{(WIDE-IDX_W){1'b0}}, i});
    aw = $signed({{(WIDE-OFF_W){1'b0}}, amt});
    return dn ? (iw + aw) : (iw - aw);
  endfunction

  logic [OFF_W-1:0]       amt;
  logic signed [WIDE-1:0] pos;
  logic signed [WIDE-1:0] lim;
  logic                   below;
  logic                   beyond;

  always_comb begin
    amt     = by_one ? OFF_W'(1) : offset;
    pos     = src_pos(down, idx, amt);
    lim     = $signed({{(WIDE-IDX_W){1'b0}}, vlmax});
    below   = pos[WIDE-1];
    beyond  = !below && (pos >= lim);
    src_idx = pos[IDX_W-1:0];
    if (by_one)      act = (below || beyond) ? ACT_SCALAR : ACT_READ;
    else if (below)  act = ACT_SKIP;
    else if (beyond) act = ACT_ZERO;
    else             act = ACT_READ;
  end
endmodule

// File: rtl/slide_seq.sv
module slide_seq
  import slide_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             launch_noop,
  input  logic             launch_bad,
  input  logic [IDX_W-1:0] vstart,
  input  logic [IDX_W-1:0] vl,
  input  logic             act_read,
  output logic [IDX_W-1:0] cur,
  output logic             busy,
  output logic             eval_active,
  output logic             rd_phase,
  output logic             done,
  output logic             exc,
  output logic             vstart_clr
);
  slide_state_e state;
  logic         exc_q;
  logic         clr_q;
  logic         in_range;

  assign in_range = cur < vl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cur   <= '0;
      exc_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (launch) begin
            exc_q <= 1'b0;
            clr_q <= 1'b0;
            cur   <= vstart;
            if (launch_noop) state <= S_DONE;
            else if (launch_bad) begin
              exc_q <= 1'b1;
              state <= S_DONE;
            end else state <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (!in_range) begin
            clr_q <= 1'b1;
            state <= S_DONE;
          end else if (act_read) state <= S_RDWAIT;
          else cur <= cur + 1'b1;
        end
        S_RDWAIT: begin
          cur   <= cur + 1'b1;
          state <= S_EVAL;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy        = (state != S_IDLE);
    eval_active = (state == S_EVAL) && in_range;
    rd_phase    = (state == S_RDWAIT);
    done        = (state == S_DONE);
    exc         = done && exc_q;
    vstart_clr  = done && clr_q;
  end
endmodule

// File: rtl/slide_unit.sv
module slide_unit
  import slide_pkg::*;
#(
  parameter int MAXVL = 64,
  parameter int OFF_W = 32,
  localparam int IDX_W = $clog2(MAXVL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_down,
  input  logic              op_by_one,
  input  logic              op_fp,
  input  logic [OFF_W-1:0]  offset,
  input  logic [ELEM_W-1:0] scalar,
  input  logic [3:0]        elem_bytes,
  input  logic [IDX_W-1:0]  vl,
  input  logic [IDX_W-1:0]  vlmax,
  input  logic [IDX_W-1:0]  vstart,
  input  logic [MAXVL-1:0]  mask,
  output logic              busy,
  output logic              done,
  output logic              exc,
  output logic              vstart_clr,
  output logic              src_rd,
  output logic [IDX_W-1:0]  src_idx,
  input  logic [ELEM_W-1:0] src_data,
  output logic              dst_we,
  output logic [IDX_W-1:0]  dst_idx,
  output logic [ELEM_W-1:0] dst_data
);
  localparam int MIDX = (MAXVL > 1) ? $clog2(MAXVL) : 1;

  // operands captured at launch
  logic              down_q, by_one_q;
  logic [OFF_W-1:0]  off_q;
  logic [ELEM_W-1:0] scalar_q;
  logic [3:0]        wb_q;
  logic [IDX_W-1:0]  vl_q, vlmax_q, vstart_q;
  logic [MAXVL-1:0]  mask_q;

  logic              launch, launch_noop, launch_bad;
  logic [IDX_W-1:0]  cur;
  logic              eval_active, rd_phase;
  slide_act_e        raw_act, act;
  logic [IDX_W-1:0]  calc_idx;
  logic              mask_bit;
  logic [ELEM_W-1:0] wmask;

  // named events for the checker
  logic ev_launch, ev_read, ev_write;

  assign launch = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      down_q   <= 1'b0;
      by_one_q <= 1'b0;
      off_q    <= '0;
      scalar_q <= '0;
      wb_q     <= '0;
      vl_q     <= '0;
      vlmax_q  <= '0;
      vstart_q <= '0;
      mask_q   <= '0;
    end else if (launch) begin
      down_q   <= op_down;
      by_one_q <= op_by_one;
      off_q    <= offset;
      scalar_q <= scalar;
      wb_q     <= elem_bytes;
      vl_q     <= vl;
      vlmax_q  <= vlmax;
      vstart_q <= vstart;
      mask_q   <= mask;
    end
  end

  slide_launch_chk #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_launch (
    .down      (op_down),
    .by_one    (op_by_one),
    .fp        (op_fp),
    .wb        (elem_bytes),
    .offset    (offset),
    .vlmax     (vlmax),
    .noop      (launch_noop),
    .bad_width (launch_bad)
  );

  slide_src_calc #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_calc (
    .down    (down_q),
    .by_one  (by_one_q),
    .idx     (cur),
    .offset  (off_q),
    .vlmax   (vlmax_q),
    .act     (raw_act),
    .src_idx (calc_idx)
  );

  slide_seq #(.IDX_W(IDX_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .launch_noop (launch_noop),
    .launch_bad  (launch_bad),
    .vstart      (vstart),
    .vl          (vl_q),
    .act_read    (act == ACT_READ),
    .cur         (cur),
    .busy        (busy),
    .eval_active (eval_active),
    .rd_phase    (rd_phase),
    .done        (done),
    .exc         (exc),
    .vstart_clr  (vstart_clr)
  );

  always_comb begin
    mask_bit  = (32'(cur) < MAXVL) ? mask_q[cur[MIDX-1:0]] : 1'b0;
    act       = mask_bit ? raw_act : ACT_SKIP;
    wmask     = width_mask(wb_q);
    ev_launch = launch;
    ev_read   = eval_active && (act == ACT_READ);
    ev_write  = rd_phase ||
                (eval_active && ((act == ACT_ZERO) || (act == ACT_SCALAR)));
    src_rd    = ev_read;
    src_idx   = calc_idx;
    dst_we    = ev_write;
    dst_idx   = cur;
    if (rd_phase)                dst_data = src_data & wmask;
    else if (act == ACT_SCALAR)  dst_data = scalar_q & wmask;
    else                         dst_data = '0;
  end
endmodule

// File: rtl/slide_unit_chk.sv
module slide_unit_chk #(
  parameter int MAXVL = 64,
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             exc,
  input logic             vstart_clr,
  input logic             ev_read,
  input logic             ev_write,
  input logic [IDX_W-1:0] src_idx,
  input logic [IDX_W-1:0] dst_idx,
  input logic [IDX_W-1:0] vl_q,
  input logic [IDX_W-1:0] vlmax_q,
  input logic [IDX_W-1:0] vstart_q,
  input logic [MAXVL-1:0] mask_q
);
  localparam int MIDX = (MAXVL > 1) ? $clog2(MAXVL) : 1;

  a_r6_write_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write |-> ((32'(dst_idx) < MAXVL) && mask_q[dst_idx[MIDX-1:0]]));

  a_r9_write_window: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write |-> ((dst_idx >= vstart_q) && (dst_idx < vl_q)));

  a_r11_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_read |=> (ev_write && (dst_idx == $past(dst_idx))));

  a_r2_read_below_vlmax: assert property (@(posedge clk) disable iff (!rst_n)
    ev_read |-> (src_idx < vlmax_q));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r7_exc_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> (done && !vstart_clr && !ev_write));
endmodule

bind slide_unit slide_unit_chk #(.MAXVL(MAXVL), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .exc        (exc),
  .vstart_clr (vstart_clr),
  .ev_read    (ev_read),
  .ev_write   (ev_write),
  .src_idx    (src_idx),
  .dst_idx    (dst_idx),
  .vl_q       (vl_q),
  .vlmax_q    (vlmax_q),
  .vstart_q   (vstart_q),
  .mask_q     (mask_q)
);

// File: tb/tb_slide_unit.sv
module tb_slide_unit;
  localparam int MAXVL = 64;
  localparam int OFF_W = 32;
  localparam int IDX_W = $clog2(MAXVL + 1);

  typedef struct {
    int          idx;
    logic [63:0] data;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              op_down = 1'b0, op_by_one = 1'b0, op_fp = 1'b0;
  logic [OFF_W-1:0]  offset = '0;
  logic [63:0]       scalar = '0;
  logic [3:0]        elem_bytes = 4'd8;
  logic [IDX_W-1:0]  vl = '0, vlmax = '0, vstart = '0;
  logic [MAXVL-1:0]  mask = '0;
  logic              busy, done, exc, vstart_clr, src_rd, dst_we;
  logic [IDX_W-1:0]  src_idx, dst_idx;
  logic [63:0]       src_data = '0;
  logic [63:0]       dst_data;

  int    checks = 0;
  int    errors = 0;
  item_t exp_q[$];
  logic  exp_exc, exp_clr;
  bit    done_seen;
  string cur_tag = "";

  always #5 clk = ~clk;

  slide_unit #(.MAXVL(MAXVL), .OFF_W(OFF_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_down(op_down),
    .op_by_one(op_by_one), .op_fp(op_fp), .offset(offset), .scalar(scalar),
    .elem_bytes(elem_bytes), .vl(vl), .vlmax(vlmax), .vstart(vstart),
    .mask(mask), .busy(busy), .done(done), .exc(exc), .vstart_clr(vstart_clr),
    .src_rd(src_rd), .src_idx(src_idx), .src_data(src_data), .dst_we(dst_we),
    .dst_idx(dst_idx), .dst_data(dst_data)
  );

  function automatic logic [63:0] srcval(input int k);
    return 64'hF0E1_D2C3_B4A5_9687 ^ (64'(k) * 64'h0102_0304_0506_0709);
  endfunction

  function automatic logic [63:0] trunc(input logic [63:0] v, input int w);
    if (w >= 8) return v;
    return v & ((64'd1 << (8 * w)) - 64'd1);
  endfunction

  // source register file model, one cycle read latency (R11)
  always_ff @(posedge clk) if (src_rd) src_data <= srcval(int'(src_idx));

  // monitor: compares writes and completion flags
  always @(negedge clk) begin
    if (rst_n) begin
      if (dst_we) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL %s: unexpected write idx=%0d data=%h, expected none",
                   cur_tag, dst_idx, dst_data);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          if (int'(dst_idx) != e.idx || dst_data !== e.data) begin
            errors++;
            $display("FAIL %s: write idx=%0d data=%h, expected idx=%0d data=%h",
                     cur_tag, dst_idx, dst_data, e.idx, e.data);
          end
        end
      end
      if (done) begin
        checks++;
        if (exc !== exp_exc || vstart_clr !== exp_clr || exp_q.size() != 0) begin
          errors++;
          $display("FAIL %s: done exc=%b clr=%b pending=%0d, expected exc=%b clr=%b pending=0",
                   cur_tag, exc, vstart_clr, exp_q.size(), exp_exc, exp_clr);
          exp_q.delete();
        end
        done_seen = 1'b1;
      end
    end
  end

  task automatic run_op(input string tag, input bit dn, input bit one, input bit fp,
                        input logic [31:0] off, input logic [63:0] sc, input int w,
                        input int n, input int nmax, input int vs,
                        input logic [63:0] m, input bit poke);
    bit legal, noop;
    noop  = !dn && !one && (longint'(off) > longint'(nmax));
    legal = fp ? (w == 4 || w == 8) : (w == 1 || w == 2 || w == 4 || w == 8);
    exp_q.delete();
    exp_exc = 1'b0;
    exp_clr = 1'b0;
    if (!noop && !legal) exp_exc = 1'b1;
    if (!noop && legal) begin
      exp_clr = 1'b1;
      for (int i = vs; i < n; i++) begin
        longint s;
        item_t  it;
        if (!m[i]) continue;
        it.idx = i;
        s = dn ? (longint'(i) + (one ? 1 : longint'(off)))
               : (longint'(i) - (one ? 1 : longint'(off)));
        if (one) begin
          if (s < 0 || s >= nmax) it.data = trunc(sc, w);
          else it.data = trunc(srcval(int'(s)), w);
        end else begin
          if (s < 0) continue;
          if (s >= nmax) it.data = 64'd0;
          else it.data = trunc(srcval(int'(s)), w);
        end
        exp_q.push_back(it);
      end
    end
    cur_tag   = tag;
    done_seen = 1'b0;
    @(negedge clk);
    op_down = dn; op_by_one = one; op_fp = fp; offset = off; scalar = sc;
    elem_bytes = 4'(w); vl = IDX_W'(n); vlmax = IDX_W'(nmax);
    vstart = IDX_W'(vs); mask = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      op_down = ~dn; offset = 32'd0; mask = '0; scalar = '1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < 2000 && !done_seen; k++) @(negedge clk);
    if (!done_seen) begin
      checks++;
      errors++;
      $display("FAIL %s: watchdog, done=0 expected done=1", tag);
      exp_q.delete();
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (busy !== 1'b0 || done !== 1'b0 || dst_we !== 1'b0 || src_rd !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset: busy=%b done=%b we=%b rd=%b expected 0000",
               busy, done, dst_we, src_rd);
    end
    rst_n = 1'b1;
    @(negedge clk);

    run_op("R1 up by 3",           0, 0, 0, 32'd3,  64'h0, 8, 16, 32, 0, '1, 0);
    run_op("R2 down by 5 tail",    1, 0, 0, 32'd5,  64'h0, 4, 32, 32, 0, '1, 0);
    run_op("R2 down huge offset",  1, 0, 0, 32'hFFFF_FFFF, 64'h0, 8, 8, 16, 0, '1, 0);
    run_op("R3 up beyond vlmax",   0, 0, 0, 32'd40, 64'h0, 8, 32, 32, 0, '1, 0);
    run_op("R3 up equal vlmax",    0, 0, 0, 32'd32, 64'h0, 8, 32, 32, 0, '1, 0);
    run_op("R3 noop beats R7",     0, 0, 0, 32'd40, 64'h0, 3, 32, 32, 0, '1, 0);
    run_op("R4 R8 one-up 16b",     0, 1, 0, 32'd0,  64'hDEAD_BEEF_CAFE_1234, 2, 12, 16, 0, '1, 0);
    run_op("R5 R8 one-down 8b",    1, 1, 0, 32'd9,  64'h0123_4567_89AB_CDA5, 1, 20, 20, 0, '1, 0);
    run_op("R5 fp one-down 64b",   1, 1, 1, 32'd0,  64'h4009_21FB_5444_2D18, 8, 10, 10, 0, '1, 0);
    run_op("R6 masked one-up",     0, 1, 0, 32'd0,  64'h77, 4, 24, 32, 0,
           64'h0000_0000_00A5_3C0F, 0);
    run_op("R6 masked down",       1, 0, 0, 32'd2,  64'h0, 8, 40, 64, 0,
           64'h0000_00F0_0F00_9981, 0);
    run_op("R7 fp width 2",        0, 1, 1, 32'd0,  64'h1, 2, 8, 8, 0, '1, 0);
    run_op("R7 int width 3",       1, 0, 0, 32'd1,  64'h1, 3, 8, 8, 0, '1, 0);
    run_op("R9 vstart 5",          1, 0, 0, 32'd1,  64'h0, 8, 12, 16, 5, '1, 0);
    run_op("R9 vstart past vl",    0, 1, 0, 32'd0,  64'h5, 8, 6, 16, 6, '1, 0);
    run_op("R10 start while busy", 0, 0, 0, 32'd1,  64'h0, 8, 16, 16, 0, '1, 1);
    run_op("R11 full 64 down",     1, 0, 0, 32'd1,  64'h0, 8, 64, 64, 0, '1, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule